// File: doc/BRIEF.md
# Shift-and-Add-Free Iterative Squarer with Divide-by-16

This block computes the square of an 8-bit unsigned operand and divides it by sixteen. It has no multiplier. The square is built one addition per clock. An odd-number register starts at 1 and rises by 2 on every step. An accumulator adds that odd number to itself on each step. After X steps the accumulator holds X squared, because the first X odd numbers sum to X squared. The completed square is then shifted right by four bit positions, and the fractional bits are dropped.

A request is one cycle of `start` while the block is idle. The operand is captured on that cycle. `busy` stays high while the operation runs, and `done` pulses for one cycle when `result` has been updated. `result` holds its value until the next operation completes.

Top module: `iter_sq16`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy` is 0, `done` is 0 and `result` is 0.
- R2: For every operand X from 0 to 255, the `result` reported with `done` equals floor(X*X/16), that is, the 16-bit square shifted right by 4 with the low bits discarded.
- R3: If `start` is sampled high at clock edge N while the block is idle, `busy` is high for cycles N+1 through N+X+1, and `done` is high only in the cycle after edge N+X+1. This gives X accumulation steps plus one finishing cycle.
- R4: X = 0 produces `result` 0, with `done` in the cycle right after the start-sampling cycle.
- R5: A `start` pulse that arrives while `busy` is high is ignored. The running operation's result and timing are unchanged, and no extra `done` is produced.
- R6: `done` is a single-cycle pulse, and `busy` is low whenever `done` is high.
- R7: `result` changes only on the cycle in which `done` is asserted. Between completions it stays stable.
- R8: The operand is captured on the accepted `start` cycle. Later changes of `x` during the operation have no effect on it.
- R9: The square is built only by addition of successive odd numbers, with no multiply operator. The 16-bit accumulator never overflows for any 8-bit operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, accepted only when idle |
| x | input | 8 | Unsigned operand, sampled with an accepted start |
| busy | output | 1 | High while an operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 12 | floor(x*x/16) of the last completed operation |

## Verification
On every cycle the assertions check several properties. The odd register must rise by exactly two on each step, and the accumulator must never carry out of 16 bits. `done` must be a one-cycle pulse that only follows a busy cycle, and `result` must hold steady except at completion. Only the bench's scenarios can show the numeric correctness of the quotient across all 256 operands and the exact X+1 cycle latency, including the zero operand. They are also the only way to show that starts issued mid-operation and operand changes during a run leave the outcome untouched.

// File: rtl/iter_sq16_pkg.sv
package iter_sq16_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } sq_state_t;
endpackage

// File: rtl/sq_ctrl.sv
module sq_ctrl
  import iter_sq16_pkg::*;
#(
  parameter int XW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [XW-1:0] x,
  output logic          load,
  output logic          step,
  output logic          finish,
  output logic          busy,
  output logic          done
);
  sq_state_t     st_q, st_d;
  logic [XW-1:0] rem_q, rem_d;
  logic          done_q;

  always_comb begin
    st_d   = st_q;
    rem_d  = rem_q;
    load   = 1'b0;
    step   = 1'b0;
    finish = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          load  = 1'b1;
          st_d  = ST_RUN;
          rem_d = x;
        end
      end
      ST_RUN: begin
        if (rem_q != '0) begin
          step  = 1'b1;
          rem_d = rem_q - XW'(1);
        end else begin
          finish = 1'b1;
          st_d   = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      rem_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= finish;
      if (load || step) rem_q <= rem_d;
    end
  end

  assign busy = (st_q == ST_RUN);
  assign done = done_q;

  // R6: done lasts one cycle and is preceded by a busy cycle
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (done && !busy));
  // R5: a start while running does not reload the counter
  a_r5_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && step) |=> (rem_q == $past(rem_q) - XW'(1)));
endmodule

// File: rtl/sq_accum.sv
module sq_accum #(
  parameter int XW = 8,
  localparam int OW = XW + 1,
  localparam int SQW = 2 * XW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  output logic [SQW-1:0] sq
);
  logic [OW-1:0]  odd_q, odd_d;
  logic [SQW-1:0] sq_q, sq_d;
  logic [SQW:0]   sum_wide;

  assign sum_wide = {1'b0, sq_q} + (SQW + 1)'(odd_q);

  always_comb begin
    odd_d = odd_q;
    sq_d  = sq_q;
    if (load) begin
      odd_d = OW'(1);
      sq_d  = '0;
    end else if (step) begin
      odd_d = odd_q + OW'(2);
      sq_d  = sum_wide[SQW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      odd_q <= OW'(1);
      sq_q  <= '0;
    end else if (load || step) begin
      odd_q <= odd_d;
      sq_q  <= sq_d;
    end
  end

  assign sq = sq_q;

  // R9: odd sequence advances by two per step
  a_r9_odd_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (odd_q == $past(odd_q) + OW'(2)));
  // R9: accumulation never carries out of the square width
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !sum_wide[SQW]);
endmodule

// File: rtl/iter_sq16.sv
module iter_sq16 #(
  parameter int XW = 8,
  parameter int SHIFT = 4,
  localparam int SQW = 2 * XW,
  localparam int RW = SQW - SHIFT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [XW-1:0] x,
  output logic          busy,
  output logic          done,
  output logic [RW-1:0] result
);
  logic           load, step, finish;
  logic [SQW-1:0] sq;
  logic [RW-1:0]  res_q, res_d;

  sq_ctrl #(.XW(XW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .x(x),
    .load(load), .step(step), .finish(finish), .busy(busy), .done(done)
  );

  sq_accum #(.XW(XW)) u_accum (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step), .sq(sq)
  );

  assign res_d = sq[SQW-1:SHIFT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_q <= '0;
    else if (finish) res_q <= res_d;
  end

  assign result = res_q;

  // R7: result moves only together with done
  a_r7_result_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));
  // R1: idle outputs right after reset
  a_r1_no_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> !done);
endmodule

// File: tb/iter_sq16_tb.sv
module iter_sq16_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 150000;

  typedef struct {
    int x;
    int exp_res;
    int exp_cyc;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [7:0]  x;
  logic        busy, done;
  logic [11:0] result;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  item_t sb[$];
  logic [11:0] prev_res;
  bit moved;
  bit prev_done;

  iter_sq16 u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .x(x),
    .busy(busy), .done(done), .result(result)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: waits for idle, issues one request, optionally disturbs it
  task automatic do_op(int xv, bit perturb);
    item_t it;
    @(negedge clk);
    while (busy) @(negedge clk);
    it.x = xv;
    it.exp_res = (xv * xv) >> 4;
    it.exp_cyc = cyc + xv + 2;
    sb.push_back(it);
    x = 8'(xv);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (perturb) begin
      x = ~8'(xv);            // R8: operand change mid-run
      @(negedge clk);
      start = 1'b1;           // R5: start while busy
      @(negedge clk);
      start = 1'b0;
    end
  endtask

  // monitor: pops expectations when done appears
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        check("R6 busy low with done", int'(busy), 0);
        check("R6 single-cycle done", int'(prev_done), 0);
        check("R7 result stable between completions", int'(moved), 0);
        moved = 1'b0;
        if (sb.size() == 0) begin
          check("R5 unexpected extra done", 1, 0);
        end else begin
          item_t it;
          it = sb.pop_front();
          if (it.x == 0) check("R4 zero operand result", int'(result), 0);
          check($sformatf("R2/R9 result x=%0d", it.x), int'(result), it.exp_res);
          check($sformatf("R3 done cycle x=%0d", it.x), cyc, it.exp_cyc);
        end
      end else if (result !== prev_res) begin
        moved = 1'b1;
      end
      prev_res = result;
      prev_done = done;
    end
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    x = '0;
    prev_res = '0;
    moved = 1'b0;
    prev_done = 1'b0;
    #(CLK_PERIOD * 3);
    // R1: reset state
    check("R1 busy in reset", int'(busy), 0);
    check("R1 done in reset", int'(done), 0);
    check("R1 result in reset", int'(result), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy after reset", int'(busy), 0);
    check("R1 result after reset", int'(result), 0);

    // R4 and R3 on the smallest operands
    do_op(0, 1'b0);
    do_op(1, 1'b0);
    do_op(0, 1'b0);
    // R2: full sweep
    for (int v = 0; v < 256; v++) do_op(v, 1'b0);
    // R5/R8: disturbed runs
    do_op(255, 1'b1);
    do_op(17, 1'b1);
    do_op(3, 1'b1);
    do_op(200, 1'b1);
    do_op(15, 1'b0);
    do_op(16, 1'b0);

    while (sb.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check("R3 busy low at end", int'(busy), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    tests++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", sb.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule